// File: doc/BRIEF.md
# Four-Channel Transfer Controller Register Unit

This unit holds the controller-wide register set of a four-channel transfer engine. A host writes an 8-bit value to one of eight control indices, selected by a 4-bit index. These writes cover the command word, software service requests, per-channel and whole-set masking, a mode byte for each channel, clearing of the shared byte pointer flag, and a master reset. The host can also read back the status word and the mask. Channel address and count registers live in a separate unit. That unit toggles the byte pointer flag, reports terminal count events and reads the mode bytes from this block's outputs.

The 8-bit status word packs four pending-request flags in bits 7:4 (channel n at bit n+4) and four terminal-count flags in bits 3:0 (channel n at bit n). Peripherals can raise or drop a request line through per-channel hold and release pulses. Reading the status word clears the terminal-count half and leaves the request half intact. A one-cycle rescan pulse tells the service arbiter to look again whenever a request, mask or reset change could alter which channel is due.

Top module: `dma_ctl_regs`

## Requirements
- R1: After the asynchronous reset the outputs are: status 0x00, mask 4'hF, command 0x00, every mode byte 0x00, byte pointer flag 0, rescan 0.
- R2: A write to index 0 loads the command register when the data is 0x00 or 0x04. Any other value (a nonzero byte with a bit among 0,1,3,4,5,6,7 set) leaves the command register unchanged.
- R3: A write to index 1 with channel c = data[1:0] sets status bit c+4 when data[2] is 1 and clears it when data[2] is 0. In both cases it clears status bit c.
- R4: A write to index 2 sets mask bit data[1:0] when data[2] is 1 and clears it when data[2] is 0. The other mask bits keep their value.
- R5: A write to index 3 stores the whole byte as the mode of channel data[1:0]. Channel n's mode appears on mode_o[8n+7:8n]. The other modes keep their value.
- R6: Each ff_toggle pulse inverts the byte pointer flag. A write to index 4 clears the flag, and the clear wins over a toggle in the same cycle.
- R7: A write to index 5 sets the flag to 0, the mask to 4'hF, the status to 0x00 and the command to 0x00. Mode bytes are kept.
- R8: A write to index 6 clears all four mask bits. A write to index 7 loads the mask from data[3:0].
- R9: rd_data is combinational. With rd_en high, index 0 returns the status, index 1 returns {4'b0, mask}, and any other index returns 0x00. With rd_en low it returns 0x00. A read of index 0 clears status bits 3:0 at the clock edge.
- R10: A hold pulse on channel n sets status bit n+4 and a release pulse clears it. A hold wins over a release, and both win over a same-cycle control write.
- R11: A tc_set pulse on channel n sets status bit n. It wins over a same-cycle clear by a request write or a status read.
- R12: rescan_o is high for exactly the one cycle after any write to index 1, 2, 5, 6 or 7 or any hold or release pulse. Writes to indices 0, 3 and 4 do not raise it.
- R13: Writes with index 8 to 15 change no register and raise no rescan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control write strobe |
| wr_idx | input | 4 | Control write index |
| wr_data | input | 8 | Control write data |
| rd_en | input | 1 | Register read strobe |
| rd_idx | input | 4 | Register read index |
| rd_data | output | 8 | Read data (combinational) |
| hold_req | input | 4 | Per-channel request raise pulses |
| release_req | input | 4 | Per-channel request drop pulses |
| tc_set | input | 4 | Per-channel terminal count pulses |
| ff_toggle | input | 1 | Byte pointer flag toggle from the channel unit |
| status_o | output | 8 | Status word |
| mask_o | output | 4 | Channel mask |
| command_o | output | 8 | Command register |
| mode_o | output | 32 | Four packed mode bytes |
| ff_o | output | 1 | Byte pointer flag |
| rescan_o | output | 1 | One-cycle arbiter rescan pulse |

## Verification
The properties assume that wr_en, rd_en and the pulse inputs are 0 while reset is asserted. They also assume that a status read and a master reset are never issued together with terminal-count pulses in a way that would hide a clear. The bench drives every input at the falling edge, holds all strobes low through reset, and raises tc_set only in cycles set aside for it. Same-cycle collisions are produced on purpose only for the precedence cases in R6, R10 and R11.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;
  localparam int NCH    = 4;
  localparam int CH_W   = $clog2(NCH);
  localparam int DW     = 8;
  localparam int IDX_W  = 4;
  localparam int STAT_W = 2 * NCH;

  localparam logic [DW-1:0] CMD_OK_BITS = 8'h04;

  typedef enum logic [2:0] {
    IX_CMD    = 3'd0,
    IX_REQ    = 3'd1,
    IX_SMASK  = 3'd2,
    IX_MODE   = 3'd3,
    IX_CLRFF  = 3'd4,
    IX_MRST   = 3'd5,
    IX_CLRMSK = 3'd6,
    IX_LDMSK  = 3'd7
  } ctl_idx_e;

  typedef struct packed {
    logic cmd;
    logic req;
    logic smask;
    logic mode;
    logic clrff;
    logic mrst;
    logic clrmsk;
    logic ldmsk;
  } wr_stb_t;
endpackage

// File: rtl/dma_ctl_decode.sv
module dma_ctl_decode
  import dma_ctl_pkg::*;
(
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  output wr_stb_t          stb
);
  always_comb begin
    stb = '0;
    if (wr_en && !wr_idx[IDX_W-1]) begin
      unique case (ctl_idx_e'(wr_idx[2:0]))
        IX_CMD:    stb.cmd    = 1'b1;
        IX_REQ:    stb.req    = 1'b1;
        IX_SMASK:  stb.smask  = 1'b1;
        IX_MODE:   stb.mode   = 1'b1;
        IX_CLRFF:  stb.clrff  = 1'b1;
        IX_MRST:   stb.mrst   = 1'b1;
        IX_CLRMSK: stb.clrmsk = 1'b1;
        IX_LDMSK:  stb.ldmsk  = 1'b1;
        default:   stb = '0;
      endcase
    end
  end
endmodule

// File: rtl/dma_ctl_status.sv
module dma_ctl_status
  import dma_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_wr,
  input  logic              mrst_wr,
  input  logic [2:0]        req_data,
  input  logic              rd_clr,
  input  logic [NCH-1:0]    hold_req,
  input  logic [NCH-1:0]    release_req,
  input  logic [NCH-1:0]    tc_set,
  output logic [STAT_W-1:0] status_q
);
  logic [STAT_W-1:0] status_d;
  logic              status_en;
  logic [CH_W-1:0]   ch;

  assign ch = req_data[CH_W-1:0];

  always_comb begin
    status_d = status_q;
    if (mrst_wr) status_d = '0;
    if (req_wr) begin
      status_d[int'(ch)]       = 1'b0;
      status_d[int'(ch) + NCH] = req_data[2];
    end
    if (rd_clr) status_d[NCH-1:0] = '0;
    status_d[STAT_W-1:NCH] = (status_d[STAT_W-1:NCH] & ~release_req) | hold_req;
    status_d[NCH-1:0]      = status_d[NCH-1:0] | tc_set;
  end

  assign status_en = req_wr | mrst_wr | rd_clr |
                     (|hold_req) | (|release_req) | (|tc_set);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         status_q <= '0;
    else if (status_en) status_q <= status_d;
  end
endmodule

// File: rtl/dma_ctl_maskmode.sv
module dma_ctl_maskmode
  import dma_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  wr_stb_t           stb,
  input  logic [DW-1:0]     wr_data,
  output logic [NCH-1:0]    mask_q,
  output logic [NCH*DW-1:0] mode_q
);
  logic [NCH-1:0]  mask_d;
  logic            mask_en;
  logic [CH_W-1:0] ch;

  assign ch = wr_data[CH_W-1:0];

  always_comb begin
    mask_d = mask_q;
    if (stb.smask)  mask_d[int'(ch)] = wr_data[2];
    if (stb.clrmsk) mask_d = '0;
    if (stb.ldmsk)  mask_d = wr_data[NCH-1:0];
    if (stb.mrst)   mask_d = '1;
  end

  assign mask_en = stb.smask | stb.clrmsk | stb.ldmsk | stb.mrst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_en) mask_q <= mask_d;
  end

  for (genvar n = 0; n < NCH; n++) begin : g_mode
    logic mode_en;
    assign mode_en = stb.mode && (ch == CH_W'(n));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mode_q[n*DW +: DW] <= '0;
      else if (mode_en) mode_q[n*DW +: DW] <= wr_data;
    end
  end
endmodule

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs
  import dma_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DW-1:0]     wr_data,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DW-1:0]     rd_data,
  input  logic [NCH-1:0]    hold_req,
  input  logic [NCH-1:0]    release_req,
  input  logic [NCH-1:0]    tc_set,
  input  logic              ff_toggle,
  output logic [STAT_W-1:0] status_o,
  output logic [NCH-1:0]    mask_o,
  output logic [DW-1:0]     command_o,
  output logic [NCH*DW-1:0] mode_o,
  output logic              ff_o,
  output logic              rescan_o
);
  wr_stb_t stb;
  logic    rd_clr;
  logic    cmd_ok, cmd_en;
  logic    ff_d, ff_en;
  logic    rescan_d;

  dma_ctl_decode u_dec (.wr_en(wr_en), .wr_idx(wr_idx), .stb(stb));

  assign rd_clr = rd_en && (rd_idx == IDX_W'(0));

  dma_ctl_status u_stat (
    .clk(clk), .rst_n(rst_n), .req_wr(stb.req), .mrst_wr(stb.mrst),
    .req_data(wr_data[2:0]), .rd_clr(rd_clr), .hold_req(hold_req),
    .release_req(release_req), .tc_set(tc_set), .status_q(status_o)
  );

  dma_ctl_maskmode u_mm (
    .clk(clk), .rst_n(rst_n), .stb(stb), .wr_data(wr_data),
    .mask_q(mask_o), .mode_q(mode_o)
  );

  // command: only the block-transfer enable bit may be set
  assign cmd_ok = (wr_data & ~CMD_OK_BITS) == '0;
  assign cmd_en = (stb.cmd && cmd_ok) || stb.mrst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      command_o <= '0;
    else if (cmd_en) command_o <= stb.mrst ? '0 : wr_data;
  end

  // byte pointer flag
  assign ff_d  = (stb.clrff || stb.mrst) ? 1'b0 : ~ff_o;
  assign ff_en = stb.clrff || stb.mrst || ff_toggle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ff_o <= 1'b0;
    else if (ff_en) ff_o <= ff_d;
  end

  // arbiter rescan pulse
  assign rescan_d = stb.req | stb.smask | stb.mrst | stb.clrmsk | stb.ldmsk |
                    (|hold_req) | (|release_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rescan_o <= 1'b0;
    else        rescan_o <= rescan_d;
  end

  // read mux
  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      if (rd_idx == IDX_W'(0))      rd_data = status_o;
      else if (rd_idx == IDX_W'(1)) rd_data = {{(DW-NCH){1'b0}}, mask_o};
    end
  end
endmodule

// File: rtl/dma_ctl_regs_chk.sv
module dma_ctl_regs_chk
  import dma_ctl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [DW-1:0]     wr_data,
  input logic              rd_en,
  input logic [IDX_W-1:0]  rd_idx,
  input logic [NCH-1:0]    hold_req,
  input logic [NCH-1:0]    tc_set,
  input logic [STAT_W-1:0] status_o,
  input logic [NCH-1:0]    mask_o,
  input logic [DW-1:0]     command_o,
  input logic              rescan_o
);
  // R2
  cmd_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (command_o == 8'h00) || (command_o == 8'h04));

  // R2
  cmd_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 4'd0 && wr_data != 8'h00 && wr_data != 8'h04)
    |=> $stable(command_o));

  // R7
  mrst_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 4'd5) |=> (mask_o == 4'hF && command_o == 8'h00));

  // R9
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_idx == 4'd0 && tc_set == 4'h0) |=> (status_o[3:0] == 4'h0));

  // R10
  hold_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|hold_req) |=> ((status_o[7:4] & $past(hold_req)) == $past(hold_req)));

  // R12
  rescan_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_idx == 4'd1 || wr_idx == 4'd2 || wr_idx == 4'd5 ||
               wr_idx == 4'd6 || wr_idx == 4'd7)) |=> rescan_o);

  // R13
  high_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx[3]) |=> ($stable(mask_o) && $stable(command_o)));
endmodule

bind dma_ctl_regs dma_ctl_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
  .rd_en(rd_en), .rd_idx(rd_idx), .hold_req(hold_req), .tc_set(tc_set),
  .status_o(status_o), .mask_o(mask_o), .command_o(command_o),
  .rescan_o(rescan_o)
);

// File: tb/dma_ctl_regs_tb.sv
module dma_ctl_regs_tb;
  localparam int CLK_P = 10;

  logic        clk, rst_n;
  logic        wr_en, rd_en, ff_toggle;
  logic [3:0]  wr_idx, rd_idx, hold_req, release_req, tc_set;
  logic [7:0]  wr_data, rd_data, status_o, command_o;
  logic [3:0]  mask_o;
  logic [31:0] mode_o;
  logic        ff_o, rescan_o;
  int          errs = 0, checks = 0;
  bit          done = 0;

  dma_ctl_regs u_dut (.*);

  initial clk = 0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; rd_en = 0; ff_toggle = 0;
    hold_req = 0; release_req = 0; tc_set = 0;
  endtask

  task automatic wr(input logic [3:0] i, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_idx = i; wr_data = d;
    @(negedge clk); idle();
  endtask

  task automatic pulse(input logic [3:0] h, r, t);
    @(negedge clk); hold_req = h; release_req = r; tc_set = t;
    @(negedge clk); idle();
  endtask

  task automatic rd(input logic [3:0] i, output logic [7:0] v);
    @(negedge clk); rd_en = 1; rd_idx = i; #1 v = rd_data;
    @(negedge clk); idle();
  endtask

  task automatic t_reset();
    chk("R1 status", status_o, 8'h00); chk("R1 mask", mask_o, 4'hF);
    chk("R1 cmd", command_o, 0); chk("R1 mode", mode_o, 0);
    chk("R1 ff", ff_o, 0); chk("R1 rescan", rescan_o, 0);
  endtask

  task automatic t_command();
    wr(0, 8'h04); chk("R2 accept", command_o, 8'h04); chk("R12 no rescan cmd", rescan_o, 0);
    wr(0, 8'h10); chk("R2 reject", command_o, 8'h04);
    wr(0, 8'h05); chk("R2 reject mixed", command_o, 8'h04);
    wr(0, 8'h00); chk("R2 zero", command_o, 8'h00);
  endtask

  task automatic t_request();
    wr(1, 8'h06); chk("R3 set ch2", status_o, 8'h40); chk("R12 rescan req", rescan_o, 1);
    @(negedge clk); chk("R12 one cycle", rescan_o, 0);
    wr(1, 8'h02); chk("R3 clear ch2", status_o, 8'h00);
    pulse(0, 0, 4'b0101); chk("R11 tc set", status_o, 8'h05);
    wr(1, 8'h04); chk("R3 clears tc bit", status_o, 8'h14);
  endtask

  task automatic t_read();
    logic [7:0] v;
    rd(0, v); chk("R9 status read", v, 8'h14); chk("R9 clear low", status_o, 8'h10);
    wr(1, 8'h00); chk("R3 clear ch0", status_o, 8'h00);
    // R11 tc wins over request-write clear
    @(negedge clk); wr_en = 1; wr_idx = 1; wr_data = 8'h01; tc_set = 4'b0010;
    @(negedge clk); idle(); chk("R11 tc over clear", status_o, 8'h02);
    @(negedge clk); rd_en = 1; rd_idx = 0; tc_set = 4'b0010;
    @(negedge clk); idle(); chk("R11 tc over read", status_o, 8'h02);
    rd(0, v); chk("R9 cleared", status_o, 8'h00);
    rd(2, v); chk("R9 other idx", v, 8'h00);
    @(negedge clk); rd_idx = 1; #1 chk("R9 rd_en low", rd_data, 8'h00);
  endtask

  task automatic t_mask();
    logic [7:0] v;
    wr(2, 8'h01); chk("R4 unmask ch1", mask_o, 4'hD); chk("R12 rescan smask", rescan_o, 1);
    wr(2, 8'h05); chk("R4 mask ch1", mask_o, 4'hF);
    wr(6, 8'hFF); chk("R8 clear all", mask_o, 4'h0); chk("R12 rescan clr", rescan_o, 1);
    wr(7, 8'hFA); chk("R8 load", mask_o, 4'hA); chk("R12 rescan ld", rescan_o, 1);
    rd(1, v); chk("R9 mask read", v, 8'h0A);
  endtask

  task automatic t_mode();
    wr(3, 8'hD6); chk("R5 ch2", mode_o, 32'h00D6_0000); chk("R12 no rescan mode", rescan_o, 0);
    wr(3, 8'h2B); chk("R5 ch3", mode_o, 32'h2BD6_0000);
  endtask

  task automatic t_ff();
    pulse(0, 0, 0);
    @(negedge clk); ff_toggle = 1; @(negedge clk); idle(); chk("R6 toggle", ff_o, 1);
    wr(4, 8'h00); chk("R6 clear", ff_o, 0); chk("R12 no rescan ff", rescan_o, 0);
    @(negedge clk); ff_toggle = 1; @(negedge clk); chk("R6 toggle2", ff_o, 1);
    wr_en = 1; wr_idx = 4; @(negedge clk); idle(); chk("R6 clear wins", ff_o, 0);
  endtask

  task automatic t_master();
    wr(0, 8'h04); wr(6, 0); wr(1, 8'h07); pulse(0, 0, 4'h8);
    @(negedge clk); ff_toggle = 1; @(negedge clk); idle();
    wr(5, 8'h00);
    chk("R7 status", status_o, 0); chk("R7 mask", mask_o, 4'hF);
    chk("R7 cmd", command_o, 0); chk("R7 ff", ff_o, 0);
    chk("R7 modes kept", mode_o, 32'h2BD6_0000); chk("R12 rescan mrst", rescan_o, 1);
  endtask

  task automatic t_hold();
    pulse(4'h8, 0, 0); chk("R10 hold", status_o, 8'h80); chk("R12 rescan hold", rescan_o, 1);
    pulse(0, 4'h8, 0); chk("R10 release", status_o, 8'h00); chk("R12 rescan rel", rescan_o, 1);
    @(negedge clk); wr_en = 1; wr_idx = 1; wr_data = 8'h03; hold_req = 4'h8;
    @(negedge clk); idle(); chk("R10 hold over write", status_o, 8'h80);
    pulse(4'h2, 4'hA, 0); chk("R10 hold over release", status_o, 8'h20);
  endtask

  task automatic t_high();
    wr(6, 0);
    wr(4'd13, 8'h00); chk("R13 mask", mask_o, 4'h0); chk("R13 status", status_o, 8'h20);
    chk("R13 rescan", rescan_o, 0);
    wr(4'd8, 8'h04); chk("R13 cmd", command_o, 8'h00);
    wr(4'd11, 8'h55); chk("R13 mode", mode_o, 32'h2BD6_0000);
  endtask

  initial begin
    idle(); wr_idx = 0; wr_data = 0; rd_idx = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset(); t_command(); t_request(); t_read(); t_mask(); t_mode();
    t_ff(); t_master(); t_hold(); t_high();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule